// File: doc/BRIEF.md
# Condition Flags and Execution Gate

This block keeps the four processor condition flags and decides, every cycle, whether the instruction now being presented may commit. Software cannot address the flags through any register number. The block reads them in two places. One is the gate that tests them against the instruction's condition mask. The other is the capture path that rewrites them when a value-producing instruction commits.

The condition field is a mask, not an enumerated condition code. Each set bit names one flag that must be set for the instruction to run, and an all-zero mask means the instruction always runs. When an instruction that yields a value commits, all four flags are rewritten from the datapath result and carry:

- C is the carry.
- N is the result's sign bit.
- Z marks an all-zero result.
- P marks a result that is neither zero nor negative.

A flag the operation does not raise is cleared. Instructions that yield no value leave the flags alone, and so does any instruction whose condition fails.

Top module: `cond_flag_gate`

## Requirements
- R1: After reset the flags output reads 4'b0000.
- R2: The condition mask and the flags share one bit order: bit 3 is C, bit 2 is N, bit 1 is Z and bit 0 is P. With instr_valid high, exec_en is high exactly when every flag named by a set mask bit is set.
- R3: A mask of 4'b0000 makes exec_en follow instr_valid whatever the flags hold.
- R4: With instr_valid low, exec_en is low, and a flag_wr strobe in that cycle leaves the flags unchanged.
- R5: When exec_en and flag_wr are both high, the flags on the next clock edge become C = alu_carry, N = alu_result MSB, Z = (alu_result == 0), P = (result not zero and MSB clear).
- R6: A flag update rewrites all four flags, so a flag that was set earlier and is not raised by the new result reads 0 afterwards. At most one of N, Z and P is ever set.
- R7: A committed instruction with flag_wr low, such as a store or a branch, leaves the flags unchanged.
- R8: An instruction whose condition fails has exec_en low and does not update the flags, even with flag_wr high.
- R9: The gate tests the flags held before the current edge. An update made by one instruction is seen by the condition test of the very next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| cond_mask | input | 4 | Required-set flag mask (C,N,Z,P from bit 3 down) |
| flag_wr | input | 1 | The instruction produces a value and updates the flags |
| alu_result | input | DATA_W | Result value from the datapath |
| alu_carry | input | 1 | Carry out from the datapath |
| exec_en | output | 1 | Instruction may commit |
| flags_o | output | 4 | Current flags (C,N,Z,P from bit 3 down) |

## Verification
The condition test and the flag capture can fall in the same cycle. This happens when a conditional, value-producing instruction is gated by the flags that its own result is about to replace. The bench provokes it with an instruction that requires Z while its own result clears Z. It judges exec_en against the old flags before the edge and the rewritten flags after it. A follow-up instruction then tests a mask against the new flags. A failed-condition instruction with flag_wr high is judged the same way, and there the flags must not move.

// File: rtl/cond_flag_pkg.sv
package cond_flag_pkg;
  localparam int CC_W = 4;
  localparam int CC_C = 3;
  localparam int CC_N = 2;
  localparam int CC_Z = 1;
  localparam int CC_P = 0;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
    logic p;
  } cc_flags_t;

  localparam cc_flags_t CC_CLEAR = '{c: 1'b0, n: 1'b0, z: 1'b0, p: 1'b0};
endpackage

// File: rtl/cond_flag_derive.sv
module cond_flag_derive #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]       result,
  input  logic                    carry,
  output cond_flag_pkg::cc_flags_t nxt
);
  import cond_flag_pkg::*;

  function automatic cc_flags_t derive(input logic [DATA_W-1:0] r, input logic c);
    cc_flags_t f;
    logic zero;
    zero = ~(|r);
    f.c  = c;
    f.n  = r[DATA_W-1];
    f.z  = zero;
    f.p  = ~zero & ~r[DATA_W-1];
    return f;
  endfunction

  assign nxt = derive(result, carry);
endmodule

// File: rtl/cond_mask_test.sv
module cond_mask_test (
  input  logic                              valid,
  input  logic [cond_flag_pkg::CC_W-1:0]    mask,
  input  logic [cond_flag_pkg::CC_W-1:0]    flags,
  output logic                              pass,
  output logic                              enable
);
  import cond_flag_pkg::*;

  logic [CC_W-1:0] bit_ok;

  for (genvar i = 0; i < CC_W; i++) begin : g_bit
    assign bit_ok[i] = ~mask[i] | flags[i];
  end

  assign pass   = &bit_ok;
  assign enable = valid & pass;
endmodule

// File: rtl/cond_flag_store.sv
module cond_flag_store (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  cond_flag_pkg::cc_flags_t  d,
  output cond_flag_pkg::cc_flags_t  q
);
  import cond_flag_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= CC_CLEAR;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cond_flag_gate.sv
module cond_flag_gate #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [3:0]        cond_mask,
  input  logic              flag_wr,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  output logic              exec_en,
  output logic [3:0]        flags_o
);
  import cond_flag_pkg::*;

  cc_flags_t flags_q;
  cc_flags_t flags_next;
  logic      cond_pass;
  logic      flag_commit;

  cond_flag_derive #(.DATA_W(DATA_W)) u_derive (
    .result (alu_result),
    .carry  (alu_carry),
    .nxt    (flags_next)
  );

  cond_mask_test u_test (
    .valid  (instr_valid),
    .mask   (cond_mask),
    .flags  (flags_q),
    .pass   (cond_pass),
    .enable (exec_en)
  );

  assign flag_commit = exec_en & flag_wr;

  cond_flag_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (flag_commit),
    .d     (flags_next),
    .q     (flags_q)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/cond_flag_gate_chk.sv
module cond_flag_gate_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [3:0]        cond_mask,
  input logic              flag_wr,
  input logic [DATA_W-1:0] alu_result,
  input logic              alu_carry,
  input logic              exec_en,
  input logic [3:0]        flags_o,
  input logic              flag_commit
);
  AST_GATE_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |-> (instr_valid && ((cond_mask & ~flags_o) == 4'b0000))); // R2
  AST_GATE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && ((cond_mask & ~flags_o) == 4'b0000)) |-> exec_en); // R2
  AST_UNCOND_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && cond_mask == 4'b0000) |-> exec_en); // R3
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !exec_en); // R4
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && flag_wr) |=> (flags_o[3] == $past(alu_carry)) &&
      (flags_o[2] == $past(alu_result[DATA_W-1])) &&
      (flags_o[1] == ($past(alu_result) == '0)) &&
      (flags_o[0] == (($past(alu_result) != '0) && !$past(alu_result[DATA_W-1])))); // R5
  AST_SIGN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags_o[2:0])); // R6
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !flag_wr) |=> $stable(flags_o)); // R7
  AST_HOLD_FAILED: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_commit |=> $stable(flags_o)); // R8
endmodule

bind cond_flag_gate cond_flag_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .cond_mask   (cond_mask),
  .flag_wr     (flag_wr),
  .alu_result  (alu_result),
  .alu_carry   (alu_carry),
  .exec_en     (exec_en),
  .flags_o     (flags_o),
  .flag_commit (flag_commit)
);

// File: tb/cond_flag_gate_test.sv
module cond_flag_gate_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         instr_valid = 1'b0;
  logic [3:0]   cond_mask = 4'b0000;
  logic         flag_wr = 1'b0;
  logic [W-1:0] alu_result = '0;
  logic         alu_carry = 1'b0;
  logic         exec_en;
  logic [3:0]   flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cond_flag_gate #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .cond_mask(cond_mask),
    .flag_wr(flag_wr), .alu_result(alu_result), .alu_carry(alu_carry),
    .exec_en(exec_en), .flags_o(flags_o)
  );

  // Reference flag model: {C,N,Z,P}
  function automatic logic [3:0] model_flags(input logic [W-1:0] r, input logic c);
    logic neg, pos, zer;
    neg = $signed(r) < 0;
    pos = $signed(r) > 0;
    zer = (r == 0);
    return {c, neg, zer, pos};
  endfunction

  function automatic logic model_gate(input logic v, input logic [3:0] m, input logic [3:0] f);
    logic ok = 1'b1;
    for (int i = 0; i < 4; i++) if (m[i] && !f[i]) ok = 1'b0;
    return v && ok;
  endfunction

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s exec_en actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req, input logic [3:0] exp);
    checks++;
    if (flags_o !== exp) begin
      errors++;
      $display("FAIL %s flags actual=%b expected=%b", req, flags_o, exp);
    end
  endtask

  // Presents one instruction for one cycle; checks exec_en before the edge.
  task automatic issue(input logic v, input logic [3:0] m, input logic u,
                       input logic [W-1:0] r, input logic c,
                       input logic exp_en, input string req);
    @(negedge clk);
    instr_valid = v; cond_mask = m; flag_wr = u; alu_result = r; alu_carry = c;
    #1;
    check1(req, exec_en, exp_en);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 1'b0; flag_wr = 1'b0; cond_mask = 4'b0000;
  endtask

  task automatic set_flags(input logic [W-1:0] r, input logic c);
    issue(1'b1, 4'b0000, 1'b1, r, c, 1'b1, "R3");
  endtask

  task automatic t_reset();
    check_flags("R1", 4'b0000);
  endtask

  task automatic t_sweep_one(input logic [3:0] f);
    for (int m = 0; m < 16; m++)
      issue(1'b1, 4'(m), 1'b0, '0, 1'b0, model_gate(1'b1, 4'(m), f), "R2");
    check_flags("R7", f);
  endtask

  task automatic t_sweep();
    logic [W-1:0] vals [3];
    vals[0] = 32'h0000_0000; vals[1] = 32'h8000_0001; vals[2] = 32'h0000_0042;
    t_sweep_one(4'b0000);
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 3; k++) begin
        set_flags(vals[k], c[0]);
        check_flags("R5", model_flags(vals[k], c[0]));
        t_sweep_one(model_flags(vals[k], c[0]));
      end
  endtask

  task automatic t_uncond();
    set_flags(32'h8000_0000, 1'b0);
    issue(1'b1, 4'b0000, 1'b0, '0, 1'b0, 1'b1, "R3");
    issue(1'b0, 4'b0000, 1'b0, '0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_idle();
    set_flags(32'h0000_0007, 1'b1);
    issue(1'b0, 4'b0000, 1'b1, '0, 1'b0, 1'b0, "R4");
    check_flags("R4", 4'b1001);
    issue(1'b0, 4'b1001, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4");
    check_flags("R4", 4'b1001);
  endtask

  task automatic t_capture();
    logic [W-1:0] r [5];
    logic         c [5];
    r[0] = 32'h0000_0000; c[0] = 1'b1;
    r[1] = 32'h8000_0000; c[1] = 1'b0;
    r[2] = 32'h0000_0005; c[2] = 1'b1;
    r[3] = 32'h7FFF_FFFF; c[3] = 1'b0;
    r[4] = 32'hFFFF_FFFF; c[4] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      set_flags(r[i], c[i]);
      check_flags("R5", model_flags(r[i], c[i]));
    end
  endtask

  task automatic t_clear();
    set_flags(32'hFFFF_FFFF, 1'b1);
    check_flags("R6", 4'b1100);
    set_flags(32'h0000_0000, 1'b0);
    check_flags("R6", 4'b0010);
  endtask

  task automatic t_noupd();
    set_flags(32'h0000_0000, 1'b1);
    issue(1'b1, 4'b1010, 1'b0, 32'h8000_0000, 1'b0, 1'b1, "R7");
    check_flags("R7", 4'b1010);
  endtask

  task automatic t_fail();
    set_flags(32'h0000_0000, 1'b0);
    issue(1'b1, 4'b1000, 1'b1, 32'h0000_0005, 1'b1, 1'b0, "R8");
    check_flags("R8", 4'b0010);
    issue(1'b1, 4'b0110, 1'b1, 32'h8000_0000, 1'b1, 1'b0, "R8");
    check_flags("R8", 4'b0010);
  endtask

  task automatic t_b2b();
    set_flags(32'h0000_0000, 1'b0);
    issue(1'b1, 4'b0010, 1'b1, 32'h0000_0005, 1'b0, 1'b1, "R9");
    check_flags("R9", 4'b0001);
    issue(1'b1, 4'b0010, 1'b0, '0, 1'b0, 1'b0, "R9");
    issue(1'b1, 4'b0001, 1'b1, 32'h8000_0000, 1'b1, 1'b1, "R9");
    check_flags("R9", 4'b1100);
    issue(1'b1, 4'b1100, 1'b0, '0, 1'b0, 1'b1, "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_sweep();
    t_uncond();
    t_idle();
    t_capture();
    t_clear();
    t_noupd();
    t_fail();
    t_b2b();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule